// File: doc/BRIEF.md
# Staggered Dead-Time Gate Generator for a Dual-Inverter Open-Winding Drive

This block turns commanded switch states into gate drive signals for a motor whose windings are open at both ends, with one inverter driving each end. Each phase has two half-bridge legs, one per inverter. A commanded bit of 1 means the upper switch conducts and the lower one is off. A bit of 0 means the opposite. Every change of a leg passes through a blanking interval in which both of its switches are off. The interval is `dt_len` timing-clock cycles long, for example 400 cycles for 4 µs at 100 MHz.

When only one inverter changes in a phase, that leg alone is blanked. When both inverters change in the same phase together, a naive generator would blank both legs at once. The freewheeling diodes would then set an unintended intermediate winding voltage. This block instead staggers the two intervals. The first interval goes to the inverter that the line current flows into, while the other leg keeps its old state. The second interval then blanks the other leg, and during it the first leg already drives its new state. The winding voltage therefore steps directly between levels.

Each phase is sequenced independently. The phase count and the counter width are parameters.

Top module: `dual_leg_deadtime`

## Requirements
- R1: After reset every leg has its upper gate off and its lower gate on. A settled leg drives upper = commanded bit and lower = its inverse.
- R2: The upper and lower gates of one leg are never on in the same cycle.
- R3: When only one inverter's bit changes in a phase, that leg is blanked (both gates off) for `dt_len` cycles. It then takes its new state. The other leg is unchanged throughout.
- R4: When both bits of a phase change together, the first interval of `dt_len` cycles blanks the leg the current flows into, and the other leg holds its previous state. `cur_dir`=1 means the current flows from inverter 1 into inverter 2, so the inverter 2 leg is blanked first. `cur_dir`=0 means the inverter 1 leg is blanked first.
- R5: In a simultaneous change, the second interval follows the first directly and lasts `dt_len` cycles. In it the first-blanked leg drives its new state and the other leg is blanked. Both legs then drive their new states.
- R6: `cur_dir` is taken when a simultaneous change starts. Changes of `cur_dir` during the sequence have no effect on the gates.
- R7: Command changes that arrive while a phase is sequencing do not alter that sequence. The latest command is applied once the sequence has completed.
- R8: A command change shows on the gates 3 clock edges after it is applied: one input register, one sequencer register and one output register.
- R9: `dt_len` is taken at the start of each interval. A value of 0 acts as 1.
- R10: The two legs of a phase are never blanked in the same cycle. Every gate that turns on was preceded by a cycle in which the other gate of its leg was off.
- R11: Phases sequence independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_inv1 | input | PHASES | Commanded upper-switch bit per phase, inverter 1 |
| cmd_inv2 | input | PHASES | Commanded upper-switch bit per phase, inverter 2 |
| cur_dir | input | PHASES | Line-current direction per phase, 1 = from inverter 1 into inverter 2 |
| dt_len | input | DT_W | Blanking interval length in clock cycles |
| gate_p1 | output | PHASES | Upper gates, inverter 1 |
| gate_n1 | output | PHASES | Lower gates, inverter 1 |
| gate_p2 | output | PHASES | Upper gates, inverter 2 |
| gate_n2 | output | PHASES | Lower gates, inverter 2 |

## Verification
A command applied before clock edge 0 first shows on the gates after edge 2.

- A single-leg change keeps the blanked pattern for `dt_len` cycles and shows the new state after edge `dt_len`+2.
- In a simultaneous change, the first staggered pattern holds through edge `dt_len`+1. The second holds from edge `dt_len`+2 through edge 2·`dt_len`+1. The final state appears after edge 2·`dt_len`+2.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from the drive point and checks the first and last cycle of each pattern, plus the cycle just before each transition. A command held pending during a sequence starts its own interval one edge after the final state appears.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SOLO   = 2'd1,
    ST_FIRST  = 2'd2,
    ST_SECOND = 2'd3
  } seq_st_t;

  // packed order p1,n1,p2,n2 (p1 is the MSB)
  typedef struct packed {
    logic p1;
    logic n1;
    logic p2;
    logic n2;
  } gate4_t;

  localparam gate4_t GATES_RESET = '{p1: 1'b0, n1: 1'b1, p2: 1'b0, n2: 1'b1};

  // complementary leg drive for a settled bit: {upper, lower}
  function automatic logic [1:0] leg_drive(input logic bit_on);
    return {bit_on, ~bit_on};
  endfunction

endpackage

// File: rtl/dtg_in_reg.sv
module dtg_in_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/dtg_timer.sv
module dtg_timer #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [DT_W-1:0] load_val,
  output logic            done
);
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/dtg_stagger_fsm.sv
module dtg_stagger_fsm
  import dtg_pkg::*;
#(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd1,
  input  logic            cmd2,
  input  logic            dir,
  input  logic [DT_W-1:0] dt_len,
  input  logic            tmr_done,
  output logic            tmr_load,
  output logic [DT_W-1:0] tmr_val,
  output gate4_t          gates
);
  seq_st_t st;
  logic    app1, app2;   // settled states
  logic    tgt1, tgt2;   // targets of the running sequence
  logic    sel2;         // leg blanked first (or alone) is inverter 2

  logic chg1, chg2;
  assign chg1 = (cmd1 != app1);
  assign chg2 = (cmd2 != app2);

  // zero length behaves as a single cycle
  assign tmr_val = (dt_len == '0) ? '0 : dt_len - 1'b1;

  always_comb begin
    tmr_load = 1'b0;
    unique case (st)
      ST_IDLE:  tmr_load = chg1 | chg2;
      ST_FIRST: tmr_load = tmr_done;
      default:  tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      app1 <= 1'b0;
      app2 <= 1'b0;
      tgt1 <= 1'b0;
      tgt2 <= 1'b0;
      sel2 <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (chg1 && chg2) begin
            st   <= ST_FIRST;
            tgt1 <= cmd1;
            tgt2 <= cmd2;
            sel2 <= dir;       // current flows into inverter 2 when dir=1
          end else if (chg1) begin
            st   <= ST_SOLO;
            tgt1 <= cmd1;
            tgt2 <= app2;
            sel2 <= 1'b0;
          end else if (chg2) begin
            st   <= ST_SOLO;
            tgt1 <= app1;
            tgt2 <= cmd2;
            sel2 <= 1'b1;
          end
        end
        ST_SOLO: begin
          if (tmr_done) begin
            app1 <= tgt1;
            app2 <= tgt2;
            st   <= ST_IDLE;
          end
        end
        ST_FIRST: begin
          if (tmr_done) st <= ST_SECOND;
        end
        ST_SECOND: begin
          if (tmr_done) begin
            app1 <= tgt1;
            app2 <= tgt2;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [1:0] leg1, leg2;
  always_comb begin
    leg1 = leg_drive(app1);
    leg2 = leg_drive(app2);
    unique case (st)
      ST_SOLO, ST_FIRST: begin
        if (sel2) leg2 = 2'b00;
        else      leg1 = 2'b00;
      end
      ST_SECOND: begin
        if (sel2) begin
          leg2 = leg_drive(tgt2);
          leg1 = 2'b00;
        end else begin
          leg1 = leg_drive(tgt1);
          leg2 = 2'b00;
        end
      end
      default: ;
    endcase
    gates = '{p1: leg1[1], n1: leg1[0], p2: leg2[1], n2: leg2[0]};
  end
endmodule

// File: rtl/dual_leg_deadtime.sv
module dual_leg_deadtime
  import dtg_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int DT_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] cmd_inv1,
  input  logic [PHASES-1:0] cmd_inv2,
  input  logic [PHASES-1:0] cur_dir,
  input  logic [DT_W-1:0]   dt_len,
  output logic [PHASES-1:0] gate_p1,
  output logic [PHASES-1:0] gate_n1,
  output logic [PHASES-1:0] gate_p2,
  output logic [PHASES-1:0] gate_n2
);
  localparam int IN_W = 3 * PHASES;

  logic [IN_W-1:0]   in_q;
  logic [PHASES-1:0] c1_q, c2_q, dir_q;

  dtg_in_reg #(.W(IN_W)) u_in (
    .clk (clk),
    .rst (rst),
    .d   ({cur_dir, cmd_inv2, cmd_inv1}),
    .q   (in_q)
  );

  assign c1_q  = in_q[PHASES-1:0];
  assign c2_q  = in_q[2*PHASES-1:PHASES];
  assign dir_q = in_q[3*PHASES-1:2*PHASES];

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
    logic            t_load, t_done;
    logic [DT_W-1:0] t_val;
    gate4_t          g_d, g_q;

    dtg_timer #(.DT_W(DT_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
    );

    dtg_stagger_fsm #(.DT_W(DT_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .cmd1     (c1_q[ph]),
      .cmd2     (c2_q[ph]),
      .dir      (dir_q[ph]),
      .dt_len   (dt_len),
      .tmr_done (t_done),
      .tmr_load (t_load),
      .tmr_val  (t_val),
      .gates    (g_d)
    );

    always_ff @(posedge clk) begin
      if (rst) g_q <= GATES_RESET;
      else     g_q <= g_d;
    end

    assign gate_p1[ph] = g_q.p1;
    assign gate_n1[ph] = g_q.n1;
    assign gate_p2[ph] = g_q.p2;
    assign gate_n2[ph] = g_q.n2;
  end
endmodule

// File: rtl/dual_leg_deadtime_chk.sv
module dual_leg_deadtime_chk #(
  parameter int PHASES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [PHASES-1:0] gate_p1,
  input logic [PHASES-1:0] gate_n1,
  input logic [PHASES-1:0] gate_p2,
  input logic [PHASES-1:0] gate_n2
);
  for (genvar ph = 0; ph < PHASES; ph++) begin : g_chk
    // R2: no shoot-through on either leg
    a_r2_leg1_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(gate_p1[ph] && gate_n1[ph]));
    a_r2_leg2_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(gate_p2[ph] && gate_n2[ph]));
    // R10: both legs never blanked together
    a_r10_one_blank: assert property (@(posedge clk) disable iff (rst)
      (gate_p1[ph] || gate_n1[ph] || gate_p2[ph] || gate_n2[ph]));
    // R10: a turn-on follows a cycle with the partner gate off
    a_r10_p1_after_off: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_p1[ph]) |-> !$past(gate_n1[ph]));
    a_r10_n1_after_off: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_n1[ph]) |-> !$past(gate_p1[ph]));
    a_r10_p2_after_off: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_p2[ph]) |-> !$past(gate_n2[ph]));
    a_r10_n2_after_off: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_n2[ph]) |-> !$past(gate_p2[ph]));
  end
endmodule

bind dual_leg_deadtime dual_leg_deadtime_chk #(.PHASES(PHASES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .gate_p1 (gate_p1),
  .gate_n1 (gate_n1),
  .gate_p2 (gate_p2),
  .gate_n2 (gate_n2)
);

// File: tb/dual_leg_deadtime_test.sv
module dual_leg_deadtime_test;
  localparam int PHASES = 3;
  localparam int DT_W   = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PHASES-1:0] c1 = '0, c2 = '0, dr = '0;
  logic [DT_W-1:0]   dt = 10'd5;
  logic [PHASES-1:0] p1, n1, p2, n2;

  int n_chk = 0;
  int n_bad = 0;
  int mon_bad = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dual_leg_deadtime #(.PHASES(PHASES), .DT_W(DT_W)) uut (
    .clk(clk), .rst(rst), .cmd_inv1(c1), .cmd_inv2(c2), .cur_dir(dr),
    .dt_len(dt), .gate_p1(p1), .gate_n1(n1), .gate_p2(p2), .gate_n2(n2)
  );

  function automatic logic [3:0] pat(input int ph);
    return {p1[ph], n1[ph], p2[ph], n2[ph]};
  endfunction

  task automatic chk(input string req, input int ph, input logic [3:0] exp);
    n_chk++;
    if (pat(ph) !== exp) begin
      n_bad++;
      $display("FAIL %s phase %0d: actual %b expected %b", req, ph, pat(ph), exp);
    end
  endtask

  task automatic neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // continuous R2 / R10 monitor at the ports
  always @(negedge clk) begin
    if (mon_on) begin
      for (int ph = 0; ph < PHASES; ph++) begin
        if ((p1[ph] && n1[ph]) || (p2[ph] && n2[ph]) || pat(ph) == 4'b0000)
          mon_bad++;
      end
    end
  end

  task automatic settle(input int ph, input logic a, input logic b);
    c1[ph] = a; c2[ph] = b;
    neg(2 * 32 + 10);
  endtask

  task automatic t_reset();
    for (int ph = 0; ph < PHASES; ph++) chk("R1 reset", ph, 4'b0101);
  endtask

  // R3 / R8: single change on inverter 1
  task automatic t_single();
    c1[0] = 1'b1;
    neg(2); chk("R8 latency", 0, 4'b0101);
    neg(1); chk("R3 blank start", 0, 4'b0001);
    neg(4); chk("R3 blank end", 0, 4'b0001);
    neg(1); chk("R1 R3 new state", 0, 4'b1001);
  endtask

  // R4 / R5 with dir=0: inverter 1 blanked first
  task automatic t_stagger_dir0();
    dr[0] = 1'b0; c1[0] = 1'b0; c2[0] = 1'b1;
    neg(3); chk("R4 first dir0", 0, 4'b0001);
    neg(4); chk("R4 first end dir0", 0, 4'b0001);
    neg(1); chk("R5 second dir0", 0, 4'b0100);
    neg(4); chk("R5 second end dir0", 0, 4'b0100);
    neg(1); chk("R5 final dir0", 0, 4'b0110);
  endtask

  // R4 / R5 synchronous turn-off, current 1 -> 2
  task automatic t_stagger_off();
    settle(0, 1'b1, 1'b1);
    chk("R1 settled", 0, 4'b1010);
    dr[0] = 1'b1; c1[0] = 1'b0; c2[0] = 1'b0;
    neg(3); chk("R4 first dir1", 0, 4'b1000);
    neg(5); chk("R5 second dir1", 0, 4'b0001);
    neg(5); chk("R5 final dir1", 0, 4'b0101);
  endtask

  // R6: direction flips mid-sequence
  task automatic t_dir_hold();
    dr[0] = 1'b1; c1[0] = 1'b1; c2[0] = 1'b1;
    neg(3); chk("R6 first", 0, 4'b0100);
    dr[0] = 1'b0;
    neg(5); chk("R6 second", 0, 4'b0010);
    neg(5); chk("R6 final", 0, 4'b1010);
  endtask

  // R7: command change during a sequence waits
  task automatic t_pending();
    dr[0] = 1'b0; c1[0] = 1'b0; c2[0] = 1'b0;
    neg(3); chk("R7 first", 0, 4'b0010);
    c1[0] = 1'b1;
    neg(5); chk("R7 second untouched", 0, 4'b0100);
    neg(5); chk("R7 final", 0, 4'b0101);
    neg(1); chk("R7 pending blank", 0, 4'b0001);
    neg(4); chk("R7 pending blank end", 0, 4'b0001);
    neg(1); chk("R7 pending applied", 0, 4'b1001);
  endtask

  // R9: zero length and length taken at interval start
  task automatic t_dt();
    dt = '0; c2[0] = 1'b1;
    neg(2); chk("R9 zero before", 0, 4'b1001);
    neg(1); chk("R9 zero blank", 0, 4'b1000);
    neg(1); chk("R9 zero done", 0, 4'b1010);
    dt = 10'd5; c2[0] = 1'b0;
    neg(3); chk("R9 blank", 0, 4'b1000);
    dt = 10'd2;
    neg(4); chk("R9 length held", 0, 4'b1000);
    neg(1); chk("R9 end", 0, 4'b1001);
    dt = 10'd5;
  endtask

  // R11: phases independent
  task automatic t_phases();
    dr[1] = 1'b1; c1[1] = 1'b1; c2[1] = 1'b1;
    c2[2] = 1'b1;
    neg(3);
    chk("R11 ph1 first", 1, 4'b0100);
    chk("R11 ph2 blank", 2, 4'b0100);
    chk("R11 ph0 quiet", 0, 4'b1001);
    neg(5);
    chk("R11 ph1 second", 1, 4'b0010);
    chk("R11 ph2 done", 2, 4'b0110);
    neg(5);
    chk("R11 ph1 final", 1, 4'b1010);
  endtask

  // R3 with the full 400-cycle interval
  task automatic t_long();
    dt = 10'd400; c2[2] = 1'b0;
    neg(3);   chk("R3 long start", 2, 4'b0100);
    neg(399); chk("R3 long end", 2, 4'b0100);
    neg(1);   chk("R3 long done", 2, 4'b0101);
    dt = 10'd5;
  endtask

  initial begin
    neg(3);
    rst = 1'b0;
    mon_on = 1'b1;
    neg(1);
    t_reset();
    t_single();
    t_stagger_dir0();
    t_stagger_off();
    t_dir_hold();
    t_pending();
    t_dt();
    t_phases();
    t_long();
    neg(3);
    n_chk++;
    if (mon_bad != 0) begin
      n_bad++;
      $display("FAIL R2 R10 monitor: actual %0d violations expected 0", mon_bad);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule